// File: doc/BRIEF.md
# Rectangular Raster-Operation Block Copier

This block moves a rectangle of bytes inside a small single-port frame memory. Each destination byte is replaced by a bitwise function of itself and the matching source byte. Software first loads a byte-wide register file through a simple write port. The register file holds the rectangle size, the two row pitches, the two start addresses, a mode byte and an 8-bit operation code. Software then sets the start bit, or uses the autostart path. The engine walks the rectangle one row at a time and works through each byte in three steps: it reads the source, reads the destination, then writes the destination back.

A mode bit reverses the walk. In reverse, both addresses count down, and the programmed start addresses name the last byte of each area. An overlapping copy toward higher addresses therefore never reads a byte it has already overwritten. Operations are selected by sparse legacy 8-bit codes. Any code outside the supported set behaves as a no-op. A run that is a no-op, or whose size does not fit the memory, finishes at once without touching memory. The memory port is a plain registered-read interface and has no back-pressure: the engine assumes read data arrives on the cycle after the address.

Top module: `blit_engine`

## Requirements
- R1: After reset, busy is 0, mem_we and mem_re are 0, and every register reads back 0.
- R2: Registers are written and read at fixed byte offsets. 16-bit fields are little-endian (low byte at the lower offset). The fields and their low-byte offsets are: width-minus-one 0x08, height-minus-one 0x0A, destination pitch 0x0C, source pitch 0x0E, destination address 0x10, source address 0x14. The single-byte registers are mode at 0x18, operation code at 0x1A and status at 0x40. In the status byte, bit 0 reads busy, bit 7 reads the autostart flag, and the other bits read 0.
- R3: Writing the status byte with bit 1 set and bit 2 clear, while idle, starts a run. Busy goes high within two cycles and stays high for exactly 3*(W+1)*(H+1) cycles. It reads 0 in the cycle after the final write.
- R4: The operation codes are 0x00 zero, 0x05 s&d, 0x09 s&~d, 0x0B ~d, 0x0D s, 0x0E all ones, 0x50 ~s&d, 0x59 s^d, 0x6D s|d, 0x90 ~s|~d, 0x95 ~(s^d), 0xAD s|~d, 0xD0 ~s, 0xD6 ~s|d and 0xDA ~s&~d, where s is the source byte and d is the destination byte.
- R5: Code 0x06, and any code not listed in R4, makes a start produce no memory write. Busy never rises for such a start.
- R6: With mode bit 0 clear, each row is processed at increasing addresses. Each following row starts one pitch above the previous row's start, for the source and the destination separately. Addresses wrap modulo the memory size.
- R7: With mode bit 0 set, each row is processed at decreasing addresses, and each following row starts one pitch below the previous row's start.
- R8: Each byte issues a source read, then a destination read, then a write to the address just read, one per cycle. A run of N bytes makes exactly N writes.
- R9: Writing the status byte with bit 2 set while a run is busy stops the run. Busy reads 0 from the next cycle, and no further write follows. Bit 2 also cancels a start bit that is written with it.
- R10: While busy, writes to every register are ignored, apart from the status bit 2 abort.
- R11: If width-minus-one or height-minus-one is at least the memory size, a start makes no write and busy stays 0.
- R12: Status bit 7 sets autostart. While it is set, an idle write to the high byte of the source address (offset 0x15) starts a run.
- R13: Mode bits [5:4] (pixel size) are stored and read back. Every value gives the same byte-wise result as 00.
- R14: Width and height registers of 0 transfer exactly one byte: three busy cycles and one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr (combinational) |
| busy | output | 1 | A run is in progress |
| mem_addr | output | ADDR_W | Frame memory byte address |
| mem_re | output | 1 | Memory read request; data expected the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |

## Verification
The hardest case to reach from the ports is an overlapping copy in reverse. Here the destination area sits two bytes above the source inside the same rows. A wrong walk order, or a wrong row step, silently copies already-overwritten bytes. The bench builds this case by programming start addresses at the last byte of each area and comparing against a reference model. The model applies the operation sequentially, in the same order, to a copy of memory. Any stray write anywhere in memory shows up in a full-memory comparison. The abort is timed mid-run, and the write counter is then watched for silence.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int REG_AW = 7;
  localparam int NUM_FIELDS = 6;

  localparam logic [REG_AW-1:0] OFS_MODE = 7'h18;
  localparam logic [REG_AW-1:0] OFS_ROP  = 7'h1A;
  localparam logic [REG_AW-1:0] OFS_STAT = 7'h40;

  // 16-bit field indices
  localparam int F_WIDTH  = 0;
  localparam int F_HEIGHT = 1;
  localparam int F_DPITCH = 2;
  localparam int F_SPITCH = 3;
  localparam int F_DADDR  = 4;
  localparam int F_SADDR  = 5;

  // status bits
  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_START_BIT = 1;
  localparam int ST_ABORT_BIT = 2;
  localparam int ST_AUTO_BIT  = 7;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_RSRC,
    WK_RDST,
    WK_WRITE
  } walk_state_t;

  // Truth table indexed by {s,d}: bit0 s0d0, bit1 s0d1, bit2 s1d0, bit3 s1d1
  typedef struct packed {
    logic       writes;
    logic [3:0] tt;
  } rop_t;

  function automatic logic [REG_AW-1:0] field_ofs(input int idx);
    case (idx)
      F_WIDTH:  field_ofs = 7'h08;
      F_HEIGHT: field_ofs = 7'h0A;
      F_DPITCH: field_ofs = 7'h0C;
      F_SPITCH: field_ofs = 7'h0E;
      F_DADDR:  field_ofs = 7'h10;
      default:  field_ofs = 7'h14;
    endcase
  endfunction

  function automatic rop_t rop_decode(input logic [7:0] code);
    rop_t r;
    r.writes = 1'b1;
    case (code)
      8'h00: r.tt = 4'b0000;
      8'h05: r.tt = 4'b1000;
      8'h09: r.tt = 4'b0100;
      8'h0B: r.tt = 4'b0101;
      8'h0D: r.tt = 4'b1100;
      8'h0E: r.tt = 4'b1111;
      8'h50: r.tt = 4'b0010;
      8'h59: r.tt = 4'b0110;
      8'h6D: r.tt = 4'b1110;
      8'h90: r.tt = 4'b0111;
      8'h95: r.tt = 4'b1001;
      8'hAD: r.tt = 4'b1101;
      8'hD0: r.tt = 4'b0011;
      8'hD6: r.tt = 4'b1011;
      8'hDA: r.tt = 4'b0001;
      default: begin
        r.tt     = 4'b1010;
        r.writes = 1'b0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              engine_busy,
  output logic [7:0]        rdata,
  output logic [15:0]       width,
  output logic [15:0]       height,
  output logic [ADDR_W-1:0] dpitch,
  output logic [ADDR_W-1:0] spitch,
  output logic [ADDR_W-1:0] daddr,
  output logic [ADDR_W-1:0] saddr,
  output logic              backward,
  output logic [7:0]        rop_code,
  output logic              start_req,
  output logic              abort_req
);

  localparam logic [REG_AW-1:0] OFS_AUTO_TRIG = field_ofs(F_SADDR) + 7'd1;

  logic [15:0] field_q [NUM_FIELDS];
  logic [7:0]  mode_q;
  logic [7:0]  rop_q;
  logic        auto_q;
  logic        start_q;
  logic        blocked;
  logic        writable;
  logic        start_hit;

  assign blocked   = engine_busy || start_q;
  assign writable  = wr_en && !blocked;
  assign abort_req = wr_en && (addr == OFS_STAT) && wdata[ST_ABORT_BIT];

  assign start_hit = writable &&
                     (((addr == OFS_STAT) && wdata[ST_START_BIT]) ||
                      (auto_q && (addr == OFS_AUTO_TRIG)));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          field_q[gi] <= '0;
        end else if (writable) begin
          if (addr == field_ofs(gi))
            field_q[gi][7:0] <= wdata;
          else if (addr == field_ofs(gi) + 7'd1)
            field_q[gi][15:8] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rop_q   <= '0;
      auto_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (writable && addr == OFS_MODE) mode_q <= wdata;
      if (writable && addr == OFS_ROP)  rop_q  <= wdata;
      if (writable && addr == OFS_STAT) auto_q <= wdata[ST_AUTO_BIT];
      start_q <= start_hit && !abort_req;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (addr == field_ofs(i))         rdata = field_q[i][7:0];
      if (addr == field_ofs(i) + 7'd1)  rdata = field_q[i][15:8];
    end
    if (addr == OFS_MODE) rdata = mode_q;
    if (addr == OFS_ROP)  rdata = rop_q;
    if (addr == OFS_STAT) begin
      rdata[ST_BUSY_BIT] = engine_busy;
      rdata[ST_AUTO_BIT] = auto_q;
    end
  end

  assign width     = field_q[F_WIDTH];
  assign height    = field_q[F_HEIGHT];
  assign dpitch    = field_q[F_DPITCH][ADDR_W-1:0];
  assign spitch    = field_q[F_SPITCH][ADDR_W-1:0];
  assign daddr     = field_q[F_DADDR][ADDR_W-1:0];
  assign saddr     = field_q[F_SADDR][ADDR_W-1:0];
  assign backward  = mode_q[0];
  assign rop_code  = rop_q;
  assign start_req = start_q;

  // R10: configuration is frozen while a run is pending or active
  a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ($stable(field_q[F_WIDTH]) && $stable(field_q[F_HEIGHT]) &&
                 $stable(field_q[F_SADDR]) && $stable(field_q[F_DADDR]) &&
                 $stable(mode_q) && $stable(rop_q)));

  // R9: abort cancels any start written with it
  a_r9_abort_cancels_start: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !start_q);

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] pitch,
  input  logic              backward,
  input  logic              step_col,
  input  logic              step_row,
  output logic [ADDR_W-1:0] cur
);

  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] next_row;
  logic [ADDR_W-1:0] next_col;

  assign next_row = backward ? (row_q - pitch) : (row_q + pitch);
  assign next_col = backward ? (cur - 1'b1)    : (cur + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      row_q <= '0;
    end else if (load) begin
      cur   <= base;
      row_q <= base;
    end else if (step_row) begin
      cur   <= next_row;
      row_q <= next_row;
    end else if (step_col) begin
      cur   <= next_col;
    end
  end

endmodule

// File: rtl/blit_alu.sv
module blit_alu #(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        tt,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] result
);

  genvar gb;
  generate
    for (gb = 0; gb < DATA_W; gb++) begin : g_bit
      assign result[gb] = tt[{src[gb], dst[gb]}];
    end
  endgenerate

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_BYTES = 4096,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              rop_writes,
  input  logic [15:0]       width,
  input  logic [15:0]       height,
  input  logic [ADDR_W-1:0] dpitch,
  input  logic [ADDR_W-1:0] spitch,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [ADDR_W-1:0] saddr,
  input  logic              backward,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] src_byte,
  output logic              busy
);

  localparam logic [16:0] SIZE_LIM = 17'(MEM_BYTES);

  walk_state_t       st_q;
  logic [15:0]       col_left;
  logic [15:0]       row_left;
  logic [15:0]       width_q;
  logic              bwd_q;
  logic              in_range;
  logic              launch;
  logic              last_col;
  logic              last_row;
  logic              step_col;
  logic              step_row;
  logic [ADDR_W-1:0] src_cur;
  logic [ADDR_W-1:0] dst_cur;

  assign in_range = ({1'b0, width} < SIZE_LIM) && ({1'b0, height} < SIZE_LIM);
  assign launch   = (st_q == WK_IDLE) && start && !abort && rop_writes && in_range;
  assign last_col = (col_left == '0);
  assign last_row = (row_left == '0);
  assign step_col = (st_q == WK_WRITE) && !abort && !last_col;
  assign step_row = (st_q == WK_WRITE) && !abort && last_col && !last_row;

  blit_addr_gen #(.ADDR_W(ADDR_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(saddr), .pitch(spitch),
    .backward(launch ? backward : bwd_q), .step_col(step_col),
    .step_row(step_row), .cur(src_cur)
  );

  blit_addr_gen #(.ADDR_W(ADDR_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(daddr), .pitch(dpitch),
    .backward(launch ? backward : bwd_q), .step_col(step_col),
    .step_row(step_row), .cur(dst_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= WK_IDLE;
      col_left <= '0;
      row_left <= '0;
      width_q  <= '0;
      bwd_q    <= 1'b0;
      src_byte <= '0;
    end else if (abort) begin
      st_q <= WK_IDLE;
    end else begin
      case (st_q)
        WK_IDLE: if (launch) begin
          st_q     <= WK_RSRC;
          col_left <= width;
          row_left <= height;
          width_q  <= width;
          bwd_q    <= backward;
        end
        WK_RSRC: st_q <= WK_RDST;
        WK_RDST: begin
          src_byte <= mem_rdata;
          st_q     <= WK_WRITE;
        end
        default: begin
          if (!last_col) begin
            col_left <= col_left - 16'd1;
            st_q     <= WK_RSRC;
          end else if (!last_row) begin
            row_left <= row_left - 16'd1;
            col_left <= width_q;
            st_q     <= WK_RSRC;
          end else begin
            st_q <= WK_IDLE;
          end
        end
      endcase
    end
  end

  assign busy     = (st_q != WK_IDLE);
  assign mem_re   = (st_q == WK_RSRC) || (st_q == WK_RDST);
  assign mem_we   = (st_q == WK_WRITE);
  assign mem_addr = (st_q == WK_RSRC) ? src_cur : dst_cur;

  // R8: a write targets the address read in the cycle before
  a_r8_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(mem_addr)));

  // R8: two reads precede every write
  a_r8_reads_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re, 1) && $past(mem_re, 2)));

  // R9: abort while busy drops busy on the next cycle
  a_r9_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> !busy);

  // R5: a run only begins for an operation that writes
  a_r5_no_run_for_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rop_writes);

  // R11: a run only begins when the size fits the memory
  a_r11_size_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> in_range);

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter  int MEM_BYTES = 4096,
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [6:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  logic [15:0]       width;
  logic [15:0]       height;
  logic [ADDR_W-1:0] dpitch;
  logic [ADDR_W-1:0] spitch;
  logic [ADDR_W-1:0] daddr;
  logic [ADDR_W-1:0] saddr;
  logic              backward;
  logic [7:0]        rop_code;
  logic              start_req;
  logic              abort_req;
  logic [7:0]        src_byte;
  rop_t              rop;

  assign rop = rop_decode(rop_code);

  blit_regs #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .engine_busy(busy), .rdata(reg_rdata),
    .width(width), .height(height), .dpitch(dpitch), .spitch(spitch),
    .daddr(daddr), .saddr(saddr), .backward(backward), .rop_code(rop_code),
    .start_req(start_req), .abort_req(abort_req)
  );

  blit_walker #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .DATA_W(8)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_req), .abort(abort_req),
    .rop_writes(rop.writes), .width(width), .height(height),
    .dpitch(dpitch), .spitch(spitch), .daddr(daddr), .saddr(saddr),
    .backward(backward), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .src_byte(src_byte), .busy(busy)
  );

  blit_alu #(.DATA_W(8)) u_alu (
    .tt(rop.tt), .src(src_byte), .dst(mem_rdata), .result(mem_wdata)
  );

  // R1: no memory traffic outside a run
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

endmodule

// File: tb/tb_blit_engine.sv
module tb_blit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 4096;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [6:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          busy;
  logic [AW-1:0] mem_addr;
  logic          mem_re;
  logic          mem_we;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;

  logic [7:0] mem     [MEMB];
  logic [7:0] exp_mem [MEMB];
  int n_checks = 0;
  int n_errors = 0;
  int n_writes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_engine #(.MEM_BYTES(MEMB)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      n_writes <= n_writes + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [7:0] model_op(input logic [7:0] code,
                                          input logic [7:0] s,
                                          input logic [7:0] d);
    case (code)
      8'h00: return 8'h00;
      8'h05: return s & d;
      8'h09: return s & ~d;
      8'h0B: return ~d;
      8'h0D: return s;
      8'h0E: return 8'hFF;
      8'h50: return ~s & d;
      8'h59: return s ^ d;
      8'h6D: return s | d;
      8'h90: return ~s | ~d;
      8'h95: return ~(s ^ d);
      8'hAD: return s | ~d;
      8'hD0: return ~s;
      8'hD6: return ~s | d;
      8'hDA: return ~s & ~d;
      default: return d;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int w, input int h, input int dp, input int sp,
                       input int da, input int sa, input logic [7:0] mode,
                       input logic [7:0] code);
    wr(7'h08, w[7:0]);  wr(7'h09, w[15:8]);
    wr(7'h0A, h[7:0]);  wr(7'h0B, h[15:8]);
    wr(7'h0C, dp[7:0]); wr(7'h0D, dp[15:8]);
    wr(7'h0E, sp[7:0]); wr(7'h0F, sp[15:8]);
    wr(7'h10, da[7:0]); wr(7'h11, da[15:8]);
    wr(7'h18, mode);    wr(7'h1A, code);
    wr(7'h14, sa[7:0]); wr(7'h15, sa[15:8]);
  endtask

  task automatic model(input int w, input int h, input int dp, input int sp,
                       input int da, input int sa, input bit bwd,
                       input logic [7:0] code);
    for (int i = 0; i < MEMB; i++) exp_mem[i] = mem[i];
    for (int r = 0; r <= h; r++)
      for (int c = 0; c <= w; c++) begin
        int s_a, d_a;
        s_a = bwd ? (sa - r*sp - c) : (sa + r*sp + c);
        d_a = bwd ? (da - r*dp - c) : (da + r*dp + c);
        s_a = s_a & (MEMB-1);
        d_a = d_a & (MEMB-1);
        exp_mem[d_a] = model_op(code, exp_mem[s_a], exp_mem[d_a]);
      end
  endtask

  task automatic wait_run(output int cycles);
    int guard = 0;
    cycles = 0;
    while (!busy && guard < 4) begin @(negedge clk); guard++; end
    while (busy && cycles < 20000) begin @(negedge clk); cycles++; end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < MEMB; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, mem[first], exp_mem[first]);
  endtask

  task automatic run_full(input string req, input int w, input int h,
                          input int dp, input int sp, input int da, input int sa,
                          input logic [7:0] mode, input logic [7:0] code);
    int cyc, w0;
    setup(w, h, dp, sp, da, sa, mode, code);
    model(w, h, dp, sp, da, sa, mode[0], code);
    w0 = n_writes;
    wr(7'h40, 8'h02);
    wait_run(cyc);
    @(negedge clk);
    compare_mem(req);
    check(cyc == 3*(w+1)*(h+1), {req, " R3 busy cycles"}, cyc, 3*(w+1)*(h+1));
    check(n_writes - w0 == (w+1)*(h+1), {req, " R8 write count"}, n_writes - w0, (w+1)*(h+1));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(mem_we == 1'b0 && mem_re == 1'b0, "R1 mem idle", {mem_we, mem_re}, 0);
    rd(7'h08, v); check(v == 8'h00, "R1 width reset", v, 0);
    rd(7'h40, v); check(v == 8'h00, "R1 status reset", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(7'h0A, 8'h34); wr(7'h0B, 8'h12);
    rd(7'h0A, v); check(v == 8'h34, "R2 height low byte", v, 8'h34);
    rd(7'h0B, v); check(v == 8'h12, "R2 height high byte", v, 8'h12);
    wr(7'h1A, 8'h59);
    rd(7'h1A, v); check(v == 8'h59, "R2 rop readback", v, 8'h59);
    wr(7'h18, 8'h30);
    rd(7'h18, v); check(v == 8'h30, "R13 pixel size stored", v, 8'h30);
  endtask

  task automatic t_nop(input logic [7:0] code);
    int w0;
    bit seen = 0;
    setup(3, 1, 16, 16, 16'h0A00, 16'h0B00, 8'h00, code);
    for (int i = 0; i < MEMB; i++) exp_mem[i] = mem[i];
    w0 = n_writes;
    wr(7'h40, 8'h02);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) seen = 1; end
    check(n_writes == w0, "R5 no writes for no-op code", n_writes - w0, 0);
    check(!seen, "R5 busy never set", seen, 0);
    compare_mem("R5 memory unchanged");
  endtask

  task automatic t_oor();
    int w0;
    bit seen = 0;
    setup(16'h1000, 0, 16, 16, 16'h0A00, 16'h0B00, 8'h00, 8'h0D);
    w0 = n_writes;
    wr(7'h40, 8'h02);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) seen = 1; end
    check(n_writes == w0 && !seen, "R11 oversize width no run", n_writes - w0, 0);
    setup(0, 16'h2000, 16, 16, 16'h0A00, 16'h0B00, 8'h00, 8'h0D);
    wr(7'h40, 8'h02);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) seen = 1; end
    check(n_writes == w0 && !seen, "R11 oversize height no run", n_writes - w0, 0);
  endtask

  task automatic t_abort_and_ignore();
    int w0, w1, total;
    logic [7:0] v;
    setup(15, 15, 32, 32, 16'h0C00, 16'h0E00, 8'h00, 8'h6D);
    w0 = n_writes;
    wr(7'h40, 8'h02);
    repeat (6) @(negedge clk);
    check(busy == 1'b1, "R3 busy during run", busy, 1);
    wr(7'h08, 8'h55);   // R10: ignored while busy
    wr(7'h1A, 8'h00);
    rd(7'h08, v); check(v == 8'h0F, "R10 width write ignored", v, 8'h0F);
    rd(7'h1A, v); check(v == 8'h6D, "R10 rop write ignored", v, 8'h6D);
    rd(7'h40, v); check(v[0] == 1'b1, "R2 status busy bit", v, 1);
    wr(7'h40, 8'h04);
    check(busy == 1'b0, "R9 busy cleared by abort", busy, 0);
    w1 = n_writes;
    repeat (20) @(negedge clk);
    check(n_writes == w1, "R9 no writes after abort", n_writes - w1, 0);
    total = n_writes - w0;
    check(total > 0 && total < 256, "R9 run cut short", total, 256);
    wr(7'h40, 8'h06);   // start with abort set: no run
    repeat (6) @(negedge clk);
    check(busy == 1'b0 && n_writes == w1, "R9 abort beats start", busy, 0);
  endtask

  task automatic t_autostart();
    int cyc;
    logic [7:0] v;
    wr(7'h40, 8'h80);
    rd(7'h40, v); check(v == 8'h80, "R12 autostart flag reads back", v, 8'h80);
    setup(4, 2, 10, 12, 16'h0600, 16'h0700, 8'h00, 8'hD0);
    model(4, 2, 10, 12, 16'h0600, 16'h0700, 1'b0, 8'hD0);
    wait_run(cyc);
    @(negedge clk);
    check(cyc == 45, "R12 autostart run length", cyc, 45);
    compare_mem("R12 autostart result");
    wr(7'h40, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < MEMB; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    // R6 forward walk with distinct pitches
    run_full("R6 forward copy", 3, 2, 20, 12, 16'h0800, 16'h0900, 8'h00, 8'h0D);
    // R4 each operation code on its own row
    begin
      logic [7:0] codes [15] = '{8'h00, 8'h05, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50,
                                 8'h59, 8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA};
      for (int k = 0; k < 15; k++)
        run_full($sformatf("R4 op %02h", codes[k]), 7, 0, 16, 16,
                 16'h0200 + k*16, 16'h0100 + k*16, 8'h00, codes[k]);
    end
    // R7 reverse overlapping copy, destination two bytes above source
    run_full("R7 reverse overlap", 5, 2, 16, 16, 16'h0400 + 32 + 5 + 2,
             16'h0400 + 32 + 5, 8'h01, 8'h0D);
    // R6 wrap at top of memory
    run_full("R6 address wrap", 3, 1, 8, 8, 16'h0FFE, 16'h0300, 8'h00, 8'h59);
    // R13 pixel-size field has no effect
    run_full("R13 pixel size 11", 2, 1, 16, 16, 16'h0500, 16'h0540, 8'h30, 8'h95);
    // R14 single byte
    run_full("R14 single byte", 0, 0, 0, 0, 16'h0580, 16'h0590, 8'h00, 8'hAD);
    t_nop(8'h06);
    t_nop(8'h33);
    t_oor();
    t_abort_and_ignore();
    t_autostart();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule